// File: doc/BRIEF.md
# Clock Frequency Strap Latch and Selection Decoder

This block decides which output frequency set a clock generator runs at. Board straps arrive on pins: two ordinary select bits, a second-level select that has already been resolved from a three-level input, and a current-multiplier strap. The block captures all of them while the active-low power-good qualifier is low. Once that qualifier goes high, the captured values are frozen, and later movement on the pins has no effect.

From the frozen straps, or from a software frequency code when the mode bit selects it, the decoder produces several results:
- a frequency index;
- a buffered-mode flag;
- a tristate flag;
- a test flag;
- the effective feedback (N) and reference (M) divider values for the synthesiser.

Software can also bypass the table entirely by enabling its own N/M pair. A one-cycle strobe marks every cycle in which the registered selection takes a new value.

All pins are plain level-sensitive control signals. The block has no data stream and no handshake, so back-pressure does not apply.

Top module: `fsel_ctrl`

## Requirements
- R1: Straps are captured on each clock edge at which `pwrgd_n` is 0. While `pwrgd_n` is 1, the captured values hold, whatever the pins do. A strap change reaches the decoded outputs two edges after it is applied.
- R2: `s2_lvl` encodes low as 0, mid as 1 and high as 2. The code 3 is captured as low.
- R3: In pin mode (`reg_mode`=0) with the second level low or high, `freq_idx` equals `s_lo` zero-extended, so 0 to 3 select CPU rates 66.67, 100, 200 and 133.33 MHz.
- R4: `buf_mode` is 1 exactly when the captured second level is high. In that mode the 66 MHz out group follows the external 66 MHz input and PCI runs at half of it.
- R5: With the second level mid, `s_lo`=0 gives `tristate`=1 and `s_lo`=1 gives `test_mode`=1. In pin mode both give `freq_idx`=0. At most one of `buf_mode`, `tristate` and `test_mode` is 1.
- R6: With the second level mid in pin mode, `s_lo`=2 gives `freq_idx`=4 (150/50/25 MHz) and `s_lo`=3 gives `freq_idx`=5 (166.67/55.56/27.78 MHz).
- R7: With `reg_mode`=1, `freq_idx` equals `reg_code` one edge after the register inputs change. The three mode flags still come from the captured straps.
- R8: With `reg_nm_en`=0, `eff_m` is 43. `eff_n` is looked up by bits [2:0] of `freq_idx` as follows: 0→200, 1→300, 2→600, 3→400, 4→450, 5→500, 6→450, 7→500.
- R9: With `reg_nm_en`=1, `eff_n` equals `reg_n` and `eff_m` equals `reg_m`, one edge after they are applied.
- R10: `sel_valid` is 1 in exactly the cycles in which any of `freq_idx`, the three flags, `eff_n` or `eff_m` has just changed. Otherwise it is 0.
- R11: Reset gives the following values: `freq_idx`=0, all flags 0, `eff_n`=200, `eff_m`=43, `sel_valid`=0 and `mult_lat`=1.
- R12: `mult_lat` carries the captured multiplier strap, taken under the same qualifier as the select straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrgd_n | input | 1 | Active-low power-good qualifier; straps are captured while it is low |
| s2_lvl | input | 2 | Pre-decoded three-level select (0 low, 1 mid, 2 high) |
| s_lo | input | 2 | Lower two select straps |
| mult_strap | input | 1 | Current-multiplier strap |
| reg_mode | input | 1 | 1 selects the software frequency code |
| reg_code | input | 5 | Software frequency code |
| reg_nm_en | input | 1 | 1 selects the software N/M pair |
| reg_n | input | 10 | Software feedback divider |
| reg_m | input | 7 | Software reference divider |
| freq_idx | output | 5 | Effective frequency index |
| buf_mode | output | 1 | Buffered 66 MHz mode |
| tristate | output | 1 | All clock outputs to high impedance |
| test_mode | output | 1 | Test-clock division mode |
| eff_n | output | 10 | Effective feedback divider |
| eff_m | output | 7 | Effective reference divider |
| mult_lat | output | 1 | Captured multiplier strap |
| sel_valid | output | 1 | One-cycle strobe on a selection change |

## Verification
A strap change travels through the capture register and then the output register, so its result is due two edges later. A change on the software inputs passes through the output register only, so its result is due one edge later. `sel_valid` rises on the same edge as the outputs it announces. Stimulus is driven on falling edges. Every check samples on the falling edge that follows the last register on its path: the second falling edge for strap vectors, and the first for the software-path and strobe checks. The strobe is checked both on a changed selection and on a rewrite of identical values.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  typedef enum logic [1:0] {
    LVL_LO  = 2'd0,
    LVL_MID = 2'd1,
    LVL_HI  = 2'd2
  } lvl_e;

  localparam int CODE_W_DEF = 5;
  localparam int N_W_DEF    = 10;
  localparam int M_W_DEF    = 7;
  localparam int M_TBL_DEF  = 43;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_n,
  input  logic [1:0] s2_lvl,
  input  logic [1:0] s_lo,
  input  logic       mult_strap,
  output lvl_e       lat_s2,
  output logic [1:0] lat_s,
  output logic       lat_mult
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_s2   <= LVL_LO;
      lat_s    <= 2'b00;
      lat_mult <= 1'b1;
    end else if (!pwrgd_n) begin
      lat_s2   <= (s2_lvl == 2'b11) ? LVL_LO : lvl_e'(s2_lvl);
      lat_s    <= s_lo;
      lat_mult <= mult_strap;
    end
  end

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwrgd_n) |-> $stable({lat_s2, lat_s, lat_mult}));
endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
  import fsel_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int N_W    = N_W_DEF,
  parameter int M_W    = M_W_DEF,
  parameter int M_TBL  = M_TBL_DEF
) (
  input  lvl_e              lat_s2,
  input  logic [1:0]        lat_s,
  input  logic              reg_mode,
  input  logic [CODE_W-1:0] reg_code,
  input  logic              reg_nm_en,
  input  logic [N_W-1:0]    reg_n,
  input  logic [M_W-1:0]    reg_m,
  output logic [CODE_W-1:0] nx_idx,
  output logic              nx_buf,
  output logic              nx_tri,
  output logic              nx_test,
  output logic [N_W-1:0]    nx_n,
  output logic [M_W-1:0]    nx_m
);
  logic [CODE_W-1:0] pin_idx;
  logic [N_W-1:0]    tbl_n;

  always_comb begin
    pin_idx = '0;
    nx_tri  = 1'b0;
    nx_test = 1'b0;
    nx_buf  = (lat_s2 == LVL_HI);
    if (lat_s2 == LVL_MID) begin
      case (lat_s)
        2'd0:    nx_tri  = 1'b1;
        2'd1:    nx_test = 1'b1;
        2'd2:    pin_idx = CODE_W'(4);
        default: pin_idx = CODE_W'(5);
      endcase
    end else begin
      pin_idx = CODE_W'(lat_s);
    end
  end

  assign nx_idx = reg_mode ? reg_code : pin_idx;

  always_comb begin
    case (nx_idx[2:0])
      3'd0:    tbl_n = N_W'(200);
      3'd1:    tbl_n = N_W'(300);
      3'd2:    tbl_n = N_W'(600);
      3'd3:    tbl_n = N_W'(400);
      3'd4:    tbl_n = N_W'(450);
      3'd5:    tbl_n = N_W'(500);
      3'd6:    tbl_n = N_W'(450);
      default: tbl_n = N_W'(500);
    endcase
  end

  assign nx_n = reg_nm_en ? reg_n : tbl_n;
  assign nx_m = reg_nm_en ? reg_m : M_W'(M_TBL);
endmodule

// File: rtl/fsel_outreg.sv
module fsel_outreg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         chg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST_VAL;
      chg <= 1'b0;
    end else begin
      chg <= (d != q);
      q   <= d;
    end
  end

  // R10
  change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (q != $past(q)));
  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> $stable(q));
endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
  import fsel_pkg::*;
#(
  parameter int CODE_W = CODE_W_DEF,
  parameter int N_W    = N_W_DEF,
  parameter int M_W    = M_W_DEF,
  parameter int M_TBL  = M_TBL_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd_n,
  input  logic [1:0]        s2_lvl,
  input  logic [1:0]        s_lo,
  input  logic              mult_strap,
  input  logic              reg_mode,
  input  logic [CODE_W-1:0] reg_code,
  input  logic              reg_nm_en,
  input  logic [N_W-1:0]    reg_n,
  input  logic [M_W-1:0]    reg_m,
  output logic [CODE_W-1:0] freq_idx,
  output logic              buf_mode,
  output logic              tristate,
  output logic              test_mode,
  output logic [N_W-1:0]    eff_n,
  output logic [M_W-1:0]    eff_m,
  output logic              mult_lat,
  output logic              sel_valid
);
  localparam int BUS_W = CODE_W + 3 + N_W + M_W;
  localparam logic [BUS_W-1:0] SEL_RST =
    {{CODE_W{1'b0}}, 3'b000, N_W'(200), M_W'(M_TBL)};

  lvl_e              lat_s2;
  logic [1:0]        lat_s;
  logic [CODE_W-1:0] nx_idx;
  logic              nx_buf, nx_tri, nx_test;
  logic [N_W-1:0]    nx_n;
  logic [M_W-1:0]    nx_m;
  logic [BUS_W-1:0]  sel_q;

  fsel_strap_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrgd_n    (pwrgd_n),
    .s2_lvl     (s2_lvl),
    .s_lo       (s_lo),
    .mult_strap (mult_strap),
    .lat_s2     (lat_s2),
    .lat_s      (lat_s),
    .lat_mult   (mult_lat)
  );

  fsel_decode #(
    .CODE_W (CODE_W),
    .N_W    (N_W),
    .M_W    (M_W),
    .M_TBL  (M_TBL)
  ) u_dec (
    .lat_s2    (lat_s2),
    .lat_s     (lat_s),
    .reg_mode  (reg_mode),
    .reg_code  (reg_code),
    .reg_nm_en (reg_nm_en),
    .reg_n     (reg_n),
    .reg_m     (reg_m),
    .nx_idx    (nx_idx),
    .nx_buf    (nx_buf),
    .nx_tri    (nx_tri),
    .nx_test   (nx_test),
    .nx_n      (nx_n),
    .nx_m      (nx_m)
  );

  fsel_outreg #(
    .W       (BUS_W),
    .RST_VAL (SEL_RST)
  ) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nx_idx, nx_buf, nx_tri, nx_test, nx_n, nx_m}),
    .q     (sel_q),
    .chg   (sel_valid)
  );

  assign {freq_idx, buf_mode, tristate, test_mode, eff_n, eff_m} = sel_q;

  // R5
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_mode, tristate, test_mode}));
endmodule

// File: tb/fsel_ctrl_bench.sv
`timescale 1ns/1ps
module fsel_ctrl_bench;
  typedef struct packed {
    logic       mode;
    logic [4:0] code;
    logic [1:0] s2;
    logic [1:0] s;
    logic [4:0] e_idx;
    logic       e_buf;
    logic       e_tri;
    logic       e_tst;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd0,  2'd0, 2'd0, 5'd0,  1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 5'd0,  2'd0, 2'd1, 5'd1,  1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 5'd0,  2'd0, 2'd2, 5'd2,  1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 5'd0,  2'd0, 2'd3, 5'd3,  1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 5'd0,  2'd2, 2'd0, 5'd0,  1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 5'd0,  2'd2, 2'd3, 5'd3,  1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 5'd0,  2'd1, 2'd0, 5'd0,  1'b0, 1'b1, 1'b0}, // R5
    '{1'b0, 5'd0,  2'd1, 2'd1, 5'd0,  1'b0, 1'b0, 1'b1}, // R5
    '{1'b0, 5'd0,  2'd1, 2'd2, 5'd4,  1'b0, 1'b0, 1'b0}, // R6
    '{1'b0, 5'd0,  2'd1, 2'd3, 5'd5,  1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 5'd5,  2'd0, 2'd2, 5'd5,  1'b0, 1'b0, 1'b0}, // R7
    '{1'b1, 5'd4,  2'd2, 2'd1, 5'd4,  1'b1, 1'b0, 1'b0}, // R7
    '{1'b1, 5'd14, 2'd1, 2'd0, 5'd14, 1'b0, 1'b1, 1'b0}, // R7
    '{1'b0, 5'd0,  2'd3, 2'd2, 5'd2,  1'b0, 1'b0, 1'b0}  // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrgd_n = 1'b1;
  logic [1:0] s2_lvl = 2'd0;
  logic [1:0] s_lo = 2'd0;
  logic mult_strap = 1'b1;
  logic reg_mode = 1'b0;
  logic [4:0] reg_code = 5'd0;
  logic reg_nm_en = 1'b0;
  logic [9:0] reg_n = 10'd0;
  logic [6:0] reg_m = 7'd0;
  logic [4:0] freq_idx;
  logic buf_mode, tristate, test_mode, mult_lat, sel_valid;
  logic [9:0] eff_n;
  logic [6:0] eff_m;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fsel_ctrl u_fsel_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .s2_lvl(s2_lvl), .s_lo(s_lo),
    .mult_strap(mult_strap), .reg_mode(reg_mode), .reg_code(reg_code),
    .reg_nm_en(reg_nm_en), .reg_n(reg_n), .reg_m(reg_m), .freq_idx(freq_idx),
    .buf_mode(buf_mode), .tristate(tristate), .test_mode(test_mode),
    .eff_n(eff_n), .eff_m(eff_m), .mult_lat(mult_lat), .sel_valid(sel_valid)
  );

  function automatic int exp_n(input logic [4:0] idx);
    case (idx[2:0])
      3'd0: return 200;
      3'd1: return 300;
      3'd2: return 600;
      3'd3: return 400;
      3'd4: return 450;
      3'd5: return 500;
      3'd6: return 450;
      default: return 500;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 idx", freq_idx, 0);
    chk("R11 flags", {buf_mode, tristate, test_mode}, 0);
    chk("R11 n", eff_n, 200);
    chk("R11 m", eff_m, 43);
    chk("R11 valid", sel_valid, 0);
    chk("R11 mult", mult_lat, 1);

    // vector walk, straps open
    pwrgd_n = 1'b0;
    for (int i = 0; i < NV; i++) begin
      reg_mode = VEC[i].mode;
      reg_code = VEC[i].code;
      s2_lvl   = VEC[i].s2;
      s_lo     = VEC[i].s;
      repeat (2) @(negedge clk);
      chk($sformatf("vec%0d idx", i), freq_idx, VEC[i].e_idx);
      chk($sformatf("vec%0d flags", i), {buf_mode, tristate, test_mode},
          {VEC[i].e_buf, VEC[i].e_tri, VEC[i].e_tst});
      chk($sformatf("R8 vec%0d n", i), eff_n, exp_n(VEC[i].e_idx));
      chk($sformatf("R8 vec%0d m", i), eff_m, 43);
    end

    // R12 multiplier strap capture
    mult_strap = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 mult low", mult_lat, 0);

    // R1 hold while qualifier high
    reg_mode = 1'b0;
    s2_lvl = 2'd1; s_lo = 2'd1;
    repeat (2) @(negedge clk);
    pwrgd_n = 1'b1;
    s2_lvl = 2'd2; s_lo = 2'd3; mult_strap = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idx held", freq_idx, 0);
    chk("R1 test held", test_mode, 1);
    chk("R1 buf held", buf_mode, 0);
    chk("R1 mult held", mult_lat, 0);

    // R7 / R10 software path, one edge
    reg_mode = 1'b1; reg_code = 5'd1;
    repeat (2) @(negedge clk);
    reg_code = 5'd3;
    @(negedge clk);
    chk("R7 idx one edge", freq_idx, 3);
    chk("R10 strobe on change", sel_valid, 1);
    @(negedge clk);
    chk("R10 strobe drops", sel_valid, 0);
    reg_code = 5'd3;
    @(negedge clk);
    chk("R10 no strobe same value", sel_valid, 0);

    // R9 software N/M
    reg_nm_en = 1'b1; reg_n = 10'd777; reg_m = 7'd99;
    @(negedge clk);
    chk("R9 n", eff_n, 777);
    chk("R9 m", eff_m, 99);
    chk("R9 strobe", sel_valid, 1);
    reg_nm_en = 1'b0;
    @(negedge clk);
    chk("R8 n back to table", eff_n, 400);

    summary();
  end
endmodule